// File: doc/BRIEF.md
# Receive Frame Phase Meter

This block reports where the recovered 8 kHz receive clock falls inside the local 2048 kbit/s backplane frame. A position counter runs through every bit of every timeslot of the local frame. The local frame pulse restarts it. The receive 8 kHz clock is asynchronous to the bit clock. It passes through a short synchroniser, and each of its rising edges captures the current position into a phase reading. The reading holds a timeslot field and a bit field.

A single frame-count bit sits above the phase reading. It flips whenever consecutive readings cross the frame boundary, in either direction. Software can then follow slow drift between the two clocks over more than one frame. A one-cycle strobe marks every new reading.

Top module: `rx_phase_meter`

## Requirements
- R1: While reset is high, the next clock edge clears the timeslot field, the bit field, the frame-count bit and the strobe.
- R2: The position advances by one bit on every clock. It steps the bit field from 0 to 7, then moves to the next timeslot, and wraps from timeslot 31 bit 7 back to timeslot 0 bit 0. A high frame pulse sends it to timeslot 0 bit 0 on that edge.
- R3: A rising edge of the receive clock that is first sampled high at clock edge k produces a new reading at edge k+2. The strobe is high for exactly the one cycle after edge k+2.
- R4: The reading equals the position held after edge k+1. The timeslot goes in the upper field and the bit in the lower field, so the linear position is timeslot*8+bit.
- R5: A falling edge, or a receive clock held steady, produces no reading and no strobe.
- R6: When a new linear reading minus the previous one is below -128, the frame-count bit toggles. This is a forward wrap past timeslot 31 bit 7.
- R7: When a new linear reading minus the previous one is above +128, the frame-count bit toggles. This is a backward wrap below timeslot 0 bit 0.
- R8: When the difference lies in -128..+128 inclusive, the frame-count bit keeps its value.
- R9: The first reading after reset never toggles the frame-count bit.
- R10: The reading and the frame-count bit hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2048 kHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Local frame pulse, restarts the position |
| rx_clk8k | input | 1 | Recovered receive 8 kHz clock, asynchronous |
| phase_slot | output | 5 | Captured timeslot |
| phase_bit | output | 3 | Captured bit within the timeslot |
| frame_bit | output | 1 | Frame-count bit, toggles on boundary wraps |
| phase_tick | output | 1 | One-cycle strobe marking a new reading |

## Verification
The bench raises the receive clock half a period before edge k. It samples the reading, the frame-count bit and the strobe 1 ns after edge k+2, which is three edges after the rise. The expected reading is the bench's own position model value after edge k+1. The frame-count bit is due on the same edge as the reading. The bench then watches the next five cycles after the receive clock falls, expecting no strobe and no change in the reading. Reset results are due one edge after reset and are checked at the next falling edge.

// File: rtl/rx_phase_meter_pkg.sv
package rx_phase_meter_pkg;

  // Kind of boundary crossing between two successive readings
  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_FWD  = 2'd1,
    WRAP_BACK = 2'd2
  } wrap_e;

  // Field width for a count of n values, never below one bit
  function automatic int field_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain;
  logic              held;

  // Stages reset high so a receive clock already high at reset is not an edge
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) held <= 1'b1;
    else     held <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~held;

endmodule

// File: rtl/frame_position_counter.sv
module frame_position_counter
  import rx_phase_meter_pkg::*;
#(
  parameter  int SLOTS  = 32,
  parameter  int BITS   = 8,
  localparam int SLOT_W = field_w(SLOTS),
  localparam int BIT_W  = field_w(BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS - 1);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      slot_o <= '0;
      bit_o  <= '0;
    end else if (bit_o == BIT_LAST) begin
      bit_o  <= '0;
      slot_o <= (slot_o == SLOT_LAST) ? '0 : slot_o + 1'b1;
    end else begin
      bit_o  <= bit_o + 1'b1;
    end
  end

endmodule

// File: rtl/phase_wrap_tracker.sv
module phase_wrap_tracker
  import rx_phase_meter_pkg::*;
#(
  parameter  int SLOTS  = 32,
  parameter  int BITS   = 8,
  localparam int SLOT_W = field_w(SLOTS),
  localparam int BIT_W  = field_w(BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic [SLOT_W-1:0] slot_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              frame_q,
  output logic              tick_q
);

  localparam int FRAME_LEN = SLOTS * BITS;
  localparam int LIN_W     = field_w(FRAME_LEN);
  localparam logic signed [LIN_W:0] HALF_S = (LIN_W+1)'(FRAME_LEN / 2);

  logic [LIN_W-1:0]        cur_lin;
  logic [LIN_W-1:0]        prev_lin;
  logic signed [LIN_W:0]   step;
  logic                    have_prev;
  wrap_e                   wrap;

  assign cur_lin = LIN_W'(slot_i) * LIN_W'(BITS) + LIN_W'(bit_i);
  assign step    = $signed({1'b0, cur_lin}) - $signed({1'b0, prev_lin});

  // Large positive jump: reading slid back below the start of the frame.
  // Large negative jump: reading moved forward past the end of the frame.
  always_comb begin
    wrap = WRAP_NONE;
    if (have_prev) begin
      if (step > HALF_S)       wrap = WRAP_BACK;
      else if (step < -HALF_S) wrap = WRAP_FWD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= '0;
      bit_q     <= '0;
      prev_lin  <= '0;
      frame_q   <= 1'b0;
      have_prev <= 1'b0;
      tick_q    <= 1'b0;
    end else begin
      tick_q <= capture_i;
      if (capture_i) begin
        slot_q    <= slot_i;
        bit_q     <= bit_i;
        prev_lin  <= cur_lin;
        have_prev <= 1'b1;
        if (wrap != WRAP_NONE) frame_q <= ~frame_q;
      end
    end
  end

endmodule

// File: rtl/rx_phase_meter.sv
module rx_phase_meter
  import rx_phase_meter_pkg::*;
#(
  parameter  int SLOTS       = 32,
  parameter  int BITS        = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int SLOT_W      = field_w(SLOTS),
  localparam int BIT_W       = field_w(BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_pulse,
  input  logic              rx_clk8k,
  output logic [SLOT_W-1:0] phase_slot,
  output logic [BIT_W-1:0]  phase_bit,
  output logic              frame_bit,
  output logic              phase_tick
);

  logic              rx_rise;
  logic [SLOT_W-1:0] pos_slot;
  logic [BIT_W-1:0]  pos_bit;

  rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (rx_clk8k),
    .rise_o  (rx_rise)
  );

  frame_position_counter #(.SLOTS(SLOTS), .BITS(BITS)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .restart_i (frame_pulse),
    .slot_o    (pos_slot),
    .bit_o     (pos_bit)
  );

  phase_wrap_tracker #(.SLOTS(SLOTS), .BITS(BITS)) u_track (
    .clk       (clk),
    .rst       (rst),
    .capture_i (rx_rise),
    .slot_i    (pos_slot),
    .bit_i     (pos_bit),
    .slot_q    (phase_slot),
    .bit_q     (phase_bit),
    .frame_q   (frame_bit),
    .tick_q    (phase_tick)
  );

endmodule

// File: rtl/rx_phase_meter_checker.sv
module rx_phase_meter_checker
  import rx_phase_meter_pkg::*;
#(
  parameter  int SLOTS       = 32,
  parameter  int BITS        = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int SLOT_W      = field_w(SLOTS),
  localparam int BIT_W       = field_w(BITS)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_clk8k,
  input logic [SLOT_W-1:0] phase_slot,
  input logic [BIT_W-1:0]  phase_bit,
  input logic              frame_bit,
  input logic              phase_tick
);

  localparam int HALF     = (SLOTS * BITS) / 2;
  localparam int AGE_LIVE = SYNC_STAGES + 4;

  int   age;
  logic seen;
  int   lin;

  always_ff @(posedge clk) begin
    if (rst) begin
      age  <= 0;
      seen <= 1'b0;
    end else begin
      if (age < AGE_LIVE) age <= age + 1;
      if (phase_tick) seen <= 1'b1;
    end
  end

  always_comb lin = int'(phase_slot) * BITS + int'(phase_bit);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (phase_slot == '0 && phase_bit == '0 && !frame_bit && !phase_tick));

  p_bit_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(phase_bit) < BITS && int'(phase_slot) < SLOTS);

  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    phase_tick |=> !phase_tick);

  p_rise_only_r5: assert property (@(posedge clk) disable iff (rst || age < AGE_LIVE)
    phase_tick |-> ($past(rx_clk8k, SYNC_STAGES + 1) && !$past(rx_clk8k, SYNC_STAGES + 2)));

  p_fwd_wrap_r6: assert property (@(posedge clk) disable iff (rst || age < AGE_LIVE)
    (phase_tick && seen && (lin - $past(lin)) < -HALF) |-> (frame_bit != $past(frame_bit)));

  p_back_wrap_r7: assert property (@(posedge clk) disable iff (rst || age < AGE_LIVE)
    (phase_tick && seen && (lin - $past(lin)) > HALF) |-> (frame_bit != $past(frame_bit)));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst || age < AGE_LIVE)
    (phase_tick && seen && (lin - $past(lin)) >= -HALF && (lin - $past(lin)) <= HALF)
      |-> $stable(frame_bit));

  p_first_quiet_r9: assert property (@(posedge clk) disable iff (rst || age < AGE_LIVE)
    (phase_tick && !seen) |-> $stable(frame_bit));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst || age < AGE_LIVE)
    !phase_tick |-> ($stable(phase_slot) && $stable(phase_bit) && $stable(frame_bit)));

endmodule

bind rx_phase_meter rx_phase_meter_checker #(
  .SLOTS       (SLOTS),
  .BITS        (BITS),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/rx_phase_meter_tb.sv
module rx_phase_meter_tb;

  localparam int SLOTS = 32;
  localparam int BITS  = 8;
  localparam int FL    = SLOTS * BITS;
  localparam int HALF  = FL / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b0;
  logic       force_fp = 1'b0;
  logic       fp;
  logic [4:0] ps;
  logic [2:0] pb;
  logic       fb;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;
  int pos_m    = 0;
  int exp_fb   = 0;
  int prev_cap = 0;
  bit first    = 1'b1;

  always #5 clk = ~clk;

  // Local frame pulse: on schedule at the end of each frame, or forced by a test
  assign fp = (pos_m == FL - 1) || force_fp;

  // Position model (R2)
  always @(posedge clk) begin
    if (rst)     pos_m <= 0;
    else if (fp) pos_m <= 0;
    else         pos_m <= (pos_m + 1) % FL;
  end

  rx_phase_meter u_dut (
    .clk         (clk),
    .rst         (rst),
    .frame_pulse (fp),
    .rx_clk8k    (rx),
    .phase_slot  (ps),
    .phase_bit   (pb),
    .frame_bit   (fb),
    .phase_tick  (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit wraps(input int prev, input int nxt, input bit is_first);
    int d;
    d = nxt - prev;
    return !is_first && (d > HALF || d < -HALF);
  endfunction

  // Raise the receive clock so that the reading lands on target, then check
  task automatic capture(input int target, input string req);
    int lin;
    bit quiet;
    @(negedge clk);
    while (pos_m != (target - 2 + FL) % FL) @(negedge clk);
    rx = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    lin = int'(ps) * BITS + int'(pb);
    if (wraps(prev_cap, target, first)) exp_fb ^= 1;
    first    = 1'b0;
    prev_cap = target;
    check(lin == target, {req, " R4 reading"}, lin, target);
    check(tick == 1'b1, "R3 strobe", int'(tick), 1);
    check(int'(fb) == exp_fb, {req, " frame bit"}, int'(fb), exp_fb);
    @(negedge clk);
    rx = 1'b0;
    quiet = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (tick || (int'(ps) * BITS + int'(pb)) != target || int'(fb) != exp_fb) quiet = 1'b0;
    end
    check(quiet, "R5 R10 falling edge quiet", int'(quiet), 1);
  endtask

  task automatic check_reset_state();
    check(ps == 5'd0 && pb == 3'd0, "R1 reading cleared", int'(ps) * BITS + int'(pb), 0);
    check(fb == 1'b0, "R1 frame bit cleared", int'(fb), 0);
    check(tick == 1'b0, "R1 strobe cleared", int'(tick), 0);
  endtask

  initial begin
    int tgt;
    void'($urandom(32'h51ab));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();
    rst = 1'b0;

    capture(200, "R9 first after reset");   // no toggle despite +200
    capture(72,  "R8 step -128");            // exactly -128, no toggle
    capture(201, "R7 back wrap +129");       // toggle
    capture(5,   "R6 fwd wrap -196");        // toggle
    capture(100, "R8 step +95");
    capture(100, "R8 step 0");
    capture(255, "R7 back wrap +155");
    capture(0,   "R6 fwd wrap -255");

    // Off-schedule frame pulse: reading must be 2 regardless of prior position (R2)
    @(negedge clk);
    while (pos_m != 100) @(negedge clk);
    force_fp = 1'b1;
    @(negedge clk);
    force_fp = 1'b0;
    rx = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    if (wraps(prev_cap, 2, first)) exp_fb ^= 1;
    prev_cap = 2;
    check(int'(ps) * BITS + int'(pb) == 2, "R2 restart by frame pulse",
          int'(ps) * BITS + int'(pb), 2);
    check(int'(fb) == exp_fb, "R8 after restart", int'(fb), exp_fb);
    @(negedge clk);
    rx = 1'b0;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 50; i++) begin
      tgt = $urandom_range(0, FL - 1);
      capture(tgt, "R6 R7 R8 random");
    end

    while (exp_fb == 0) capture((prev_cap < 128) ? 255 : 0, "R6 R7 set frame bit");

    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    first = 1'b1; exp_fb = 0; prev_cap = 0;
    capture(200, "R9 first after second reset");
    capture(40,  "R6 fwd wrap -160");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++;
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule